// File: doc/BRIEF.md
# Three-Bus Datapath with Step Sequencer

This block is a small processor datapath built around three internal buses. A register file with two read ports puts two operands on buses A and B in the same cycle. An ALU combines them and drives its result onto bus C. Bus C feeds the register file's single write port and also the address and instruction registers. The program counter has its own incrementer, so the ALU is never busy with the PC. Because of this, the datapath needs no temporary operand or result registers.

A four-step sequencer drives all control signals. In the first step the PC goes through the ALU into the memory address register and the PC advances. In the second step the sequencer holds a read request until memory signals completion, and the returned word is captured. In the third step the captured word is routed over bus B into the instruction register. In the fourth step the decoded instruction runs and its completion is flagged. Memory is a simple request/complete handshake: the block holds `mem_read` until `mem_mfc` is seen high at a clock edge.

An instruction is a 32-bit word with four fields, from the top down: opcode in bits [31:26], destination in [25:21], first source in [20:16] and second source in [15:11]. Bits [10:0] are ignored. Opcode 6'h01 adds the two sources. Opcode 6'h02 copies the first source. Every other opcode completes without writing anything.

Top module: `tribus_core`

## Requirements
- R1: While `rst` is high at a clock edge, the PC and the address register return to 0, `mem_read`, `wb_en` and `instr_done` are 0, and every register k of the file returns to the value k. This also holds when reset arrives in the middle of an instruction.
- R2: In the fetch step, `res_bus` carries the current PC, passed through unchanged by the ALU. The PC then advances by 4. The fetch addresses of successive instructions are 0, 4, 8, and so on.
- R3: From the cycle after the fetch step, `mem_read` stays high with a stable `mem_addr` equal to the fetched PC. It stays high until a clock edge at which `mem_mfc` is high, and it is low in the following cycle. A wait of zero extra cycles is allowed.
- R4: The word on `mem_rdata` at the completing edge is captured. In the next cycle that word appears unchanged on `res_bus` while it loads the instruction register.
- R5: With opcode 6'h01, the execute step drives the 32-bit sum of the registers named in bits [20:16] and [15:11] onto `res_bus`. It asserts `wb_en` with `wb_idx` equal to bits [25:21], and the register holds the sum afterwards.
- R6: When the destination register is also a source, the sources read the value from before the write in that same cycle. The new value is visible to later instructions.
- R7: With opcode 6'h02, the execute step copies the register named in bits [20:16] unchanged to `res_bus` and writes it to the destination register.
- R8: With any opcode other than 6'h01 or 6'h02, the execute step asserts `instr_done` with `wb_en` low, and no register changes.
- R9: `instr_done` is high for exactly the one execute cycle of each instruction, with `mem_read` low. The next cycle is the fetch step of the following instruction.
- R10: Register 0 is an ordinary register that can be written and read back like any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Memory address register contents |
| mem_read | output | 1 | Read request, held until completion |
| mem_rdata | input | 32 | Word returned by memory |
| mem_mfc | input | 1 | Memory completion flag for the pending read |
| res_bus | output | 32 | Value on bus C (ALU result) |
| wb_en | output | 1 | Register file write strobe this cycle |
| wb_idx | output | 5 | Register file write index |
| instr_done | output | 1 | Execute step of an instruction, last cycle |

## Verification
The hardest situation to reach is a same-cycle conflict in which a register is both read and written. The bench runs an add whose destination is also both of its sources, and it checks the doubled result against the value from before the write. Unknown opcodes leave no trace on the outputs. The bench therefore follows such an instruction with an add that reads the would-be destination and confirms its original value. Memory completion is given after zero, short and long waits, and a reset is applied while a read is pending. In each case the bench then confirms that fetching restarts at address 0 with register contents restored.

// File: rtl/tribus_pkg.sv
package tribus_pkg;

    localparam int XLEN    = 32;
    localparam int NREG    = 32;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int OPC_W   = 6;
    localparam int PC_STEP = 4;

    localparam logic [OPC_W-1:0] OPC_ADD = 6'h01;
    localparam logic [OPC_W-1:0] OPC_MOV = 6'h02;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_WAIT,
        ST_IR,
        ST_EXEC
    } step_e;

    typedef enum logic [1:0] {
        ALU_PASS_A,
        ALU_PASS_B,
        ALU_ADD
    } alu_op_e;

    typedef enum logic [1:0] {
        BSRC_RF,
        BSRC_PC,
        BSRC_MDR
    } bsrc_e;

    // Decoded fields kept in the instruction register (upper bits of the word)
    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] srca;
        logic [RIDX_W-1:0] srcb;
    } ifield_t;

    localparam int IFIELD_W = $bits(ifield_t);

    typedef struct packed {
        bsrc_e   bsrc;
        alu_op_e alu_op;
        logic    mar_ld;
        logic    pc_inc;
        logic    mem_read;
        logic    mdr_ld;
        logic    ir_ld;
        logic    rf_we;
        logic    done;
    } ctrl_t;

    function automatic logic opc_writes(input logic [OPC_W-1:0] opc);
        return (opc == OPC_ADD) || (opc == OPC_MOV);
    endfunction

    function automatic alu_op_e opc_alu(input logic [OPC_W-1:0] opc);
        return (opc == OPC_MOV) ? ALU_PASS_A : ALU_ADD;
    endfunction

endpackage

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
    parameter int W  = 32,
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [IW-1:0] w_idx,
    input  logic [W-1:0]  w_data
);

    logic [W-1:0] regs [N];

    // Reads are combinational from the stored array: a write in the same
    // cycle lands at the edge, so readers see the previous contents.
    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) begin
                regs[k] <= W'(k);
            end
        end else if (we) begin
            regs[w_idx] <= w_data;
        end
    end

endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
    import tribus_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_PASS_A: y = a;
            ALU_PASS_B: y = b;
            ALU_ADD:    y = a + b;
            default:    y = b;
        endcase
    end

endmodule

// File: rtl/tribus_stepper.sv
module tribus_stepper
    import tribus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mfc,
    input  logic [OPC_W-1:0] opcode,
    output ctrl_t            ctrl
);

    step_e step_q, step_d;

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_FETCH;
        else     step_q <= step_d;
    end

    always_comb begin
        ctrl        = '0;
        ctrl.bsrc   = BSRC_PC;
        ctrl.alu_op = ALU_PASS_B;
        step_d      = step_q;
        unique case (step_q)
            ST_FETCH: begin
                ctrl.mar_ld = 1'b1;
                ctrl.pc_inc = 1'b1;
                step_d      = ST_WAIT;
            end
            ST_WAIT: begin
                ctrl.mem_read = 1'b1;
                if (mfc) begin
                    ctrl.mdr_ld = 1'b1;
                    step_d      = ST_IR;
                end
            end
            ST_IR: begin
                ctrl.bsrc  = BSRC_MDR;
                ctrl.ir_ld = 1'b1;
                step_d     = ST_EXEC;
            end
            ST_EXEC: begin
                ctrl.bsrc   = BSRC_RF;
                ctrl.alu_op = opc_alu(opcode);
                ctrl.rf_we  = opc_writes(opcode);
                ctrl.done   = 1'b1;
                step_d      = ST_FETCH;
            end
            default: step_d = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/tribus_core.sv
module tribus_core
    import tribus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_read,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_mfc,
    output logic [XLEN-1:0]   res_bus,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic              instr_done
);

    ctrl_t           ctrl;
    ifield_t         ir_q;
    logic [XLEN-1:0] pc_q, mar_q, mdr_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] bus_a, bus_b, bus_c;
    logic [XLEN-1:0] rf_b;

    tribus_stepper u_step (
        .clk    (clk),
        .rst    (rst),
        .mfc    (mem_mfc),
        .opcode (ir_q.opcode),
        .ctrl   (ctrl)
    );

    tribus_regfile #(
        .W (XLEN),
        .N (NREG)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (ir_q.srca),
        .ra_data (bus_a),
        .rb_idx  (ir_q.srcb),
        .rb_data (rf_b),
        .we      (ctrl.rf_we),
        .w_idx   (ir_q.dst),
        .w_data  (bus_c)
    );

    always_comb begin
        unique case (ctrl.bsrc)
            BSRC_PC:  bus_b = pc_q;
            BSRC_MDR: bus_b = mdr_q;
            default:  bus_b = rf_b;
        endcase
    end

    tribus_alu #(.W(XLEN)) u_alu (
        .a  (bus_a),
        .b  (bus_b),
        .op (ctrl.alu_op),
        .y  (bus_c)
    );

    // Dedicated PC incrementer, independent of the ALU
    assign pc_next = pc_q + XLEN'(PC_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
        end else begin
            if (ctrl.mar_ld) mar_q <= bus_c;
            if (ctrl.pc_inc) pc_q  <= pc_next;
            if (ctrl.mdr_ld) mdr_q <= mem_rdata;
            if (ctrl.ir_ld)  ir_q  <= bus_c[XLEN-1 -: IFIELD_W];
        end
    end

    assign mem_addr   = mar_q;
    assign mem_read   = ctrl.mem_read;
    assign res_bus    = bus_c;
    assign wb_en      = ctrl.rf_we;
    assign wb_idx     = ir_q.dst;
    assign instr_done = ctrl.done;

endmodule

// File: rtl/tribus_core_chk.sv
module tribus_core_chk
    import tribus_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_read,
    input logic            mem_mfc,
    input logic            wb_en,
    input logic            instr_done
);

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_read && !mem_mfc) |=> (mem_read && $stable(mem_addr))); // R3

    AST_READ_DROP: assert property (@(posedge clk) disable iff (rst)
        (mem_read && mem_mfc) |=> !mem_read); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> !instr_done); // R9

    AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        instr_done |-> !mem_read); // R9

    AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> instr_done); // R5

endmodule

bind tribus_core tribus_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_read   (mem_read),
    .mem_mfc    (mem_mfc),
    .wb_en      (wb_en),
    .instr_done (instr_done)
);

// File: tb/tribus_core_bench.sv
`timescale 1ns/1ps
module tribus_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr;
    logic        mem_read;
    logic [31:0] mem_rdata = '0;
    logic        mem_mfc = 1'b0;
    logic [31:0] res_bus;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic        instr_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] model [32];
    logic [31:0] exp_pc;

    always #2.5 clk = ~clk;

    tribus_core u_tribus_core (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_read   (mem_read),
        .mem_rdata  (mem_rdata),
        .mem_mfc    (mem_mfc),
        .res_bus    (res_bus),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .instr_done (instr_done)
    );

    // Entry: {wait cycles[7:0], opcode[5:0], dst[4:0], srca[4:0], srcb[4:0]}
    localparam int NVEC = 8;
    localparam logic [28:0] VEC [NVEC] = '{
        {8'd0, 6'h01, 5'd1,  5'd2,  5'd3},   // R5: r1 = 2 + 3
        {8'd2, 6'h01, 5'd3,  5'd3,  5'd3},   // R6: r3 = r3 + r3 reads old 3
        {8'd1, 6'h02, 5'd0,  5'd31, 5'd4},   // R7 R10: r0 <- r31
        {8'd5, 6'h01, 5'd4,  5'd0,  5'd1},   // R10: r4 = r0 + r1
        {8'd0, 6'h3F, 5'd5,  5'd1,  5'd1},   // R8: unknown opcode, r5 untouched
        {8'd3, 6'h01, 5'd6,  5'd5,  5'd5},   // R8: r6 = r5 + r5 shows r5 intact
        {8'd1, 6'h01, 5'd7,  5'd31, 5'd31},  // R5
        {8'd4, 6'h02, 5'd2,  5'd4,  5'd9}    // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 32; k++) model[k] = 32'(k);
        exp_pc = '0;
    endtask

    // Called at a falling edge while the fetch step is on the outputs.
    task automatic run_instr(input logic [5:0] op, input logic [4:0] d,
                             input logic [4:0] sa, input logic [4:0] sb,
                             input int lat);
        logic [31:0] word;
        logic [31:0] exp_v;
        logic        wr;
        string       tag;
        word = {op, d, sa, sb, 11'h5A5};
        check("R2 fetch bus carries PC", res_bus, exp_pc);
        check("R9 no done in fetch", {31'd0, instr_done}, 32'd0);
        @(negedge clk);
        check("R3 read raised", {31'd0, mem_read}, 32'd1);
        check("R2 fetch address", mem_addr, exp_pc);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check("R3 read held", {31'd0, mem_read}, 32'd1);
            check("R3 address stable", mem_addr, exp_pc);
        end
        mem_mfc   = 1'b1;
        mem_rdata = word;
        @(negedge clk);
        mem_mfc   = 1'b0;
        mem_rdata = 32'hDEAD_BEEF;
        check("R3 read dropped", {31'd0, mem_read}, 32'd0);
        check("R4 word on bus", res_bus, word);
        @(negedge clk);
        wr    = (op == 6'h01) || (op == 6'h02);
        exp_v = (op == 6'h01) ? model[sa] + model[sb] : model[sa];
        tag   = (op == 6'h01) ? "R5" : (op == 6'h02) ? "R7" : "R8";
        check("R9 done in execute", {31'd0, instr_done}, 32'd1);
        check({tag, " write strobe"}, {31'd0, wb_en}, {31'd0, wr});
        if (wr) begin
            check({tag, " write index"}, {27'd0, wb_idx}, {27'd0, d});
            check({tag, " result"}, res_bus, exp_v);
            model[d] = exp_v;
        end
        exp_pc = exp_pc + 32'd4;
        @(negedge clk);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset read", {31'd0, mem_read}, 32'd0);
        check("R1 reset addr", mem_addr, 32'd0);
        check("R1 reset done", {31'd0, instr_done}, 32'd0);
        check("R1 reset wb", {31'd0, wb_en}, 32'd0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            run_instr(VEC[v][20:15], VEC[v][14:10], VEC[v][9:5], VEC[v][4:0],
                      int'(VEC[v][28:21]));
        end

        // R1: reset while a read is pending
        @(negedge clk);
        check("R1 pending read before reset", {31'd0, mem_read}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 read cleared", {31'd0, mem_read}, 32'd0);
        check("R1 addr cleared", mem_addr, 32'd0);
        rst = 1'b0;
        model_reset();
        run_instr(6'h01, 5'd9, 5'd1, 5'd3, 1);   // R1: sees reset values 1 + 3
        run_instr(6'h01, 5'd0, 5'd0, 5'd0, 0);   // R10 R6: r0 = 0 + 0

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100us;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule